// File: doc/BRIEF.md
# Cascadable Latched Serial-to-Parallel Driver Register

This block is a serial-in, parallel-out register for driving a row of low-side load switches. Bits arrive one per rising edge of a shift clock and pass through a shift chain. A separate load clock copies the whole chain into a holding register in parallel, so the outputs change only when a complete word has been assembled. An active-low enable gates the held word onto the switch-control outputs. When the enable is inactive, every switch is off.

Several stages can be chained by wiring the serial output of one stage to the serial input of the next. The serial output is retimed on the falling edge of the shift clock. The next stage therefore sees a bit that stays stable across its own rising edge, which gives it half a clock period of hold margin.

A single active-low clear empties the shift chain, the holding register and the cascade flop at once. The clear takes effect asynchronously. Its release is synchronised separately to each clock edge that a register set uses.

Top module: `drv_latched_sipo`

## Requirements
- R1: On each rising shift-clock edge, the serial input enters chain bit 0 and every chain bit moves up one position. Bit WIDTH-1 is the last stage.
- R2: The holding register changes only on a rising load-clock edge. On that edge it captures all WIDTH chain bits in parallel. Shifting without a load edge leaves the switch outputs unchanged.
- R3: While the clear input is 0, the chain, the holding register and the serial output all read 0. The switch outputs are therefore all 0 as well.
- R4: While the enable input is 1, all switch outputs are 0 (off). The holding register is not altered: when the enable returns to 0, the outputs show the word that was held before.
- R5: While the enable input is 0, switch output bit i equals holding-register bit i. A 1 turns the switch on.
- R6: The serial output takes the value of chain bit WIDTH-1 on the falling shift-clock edge. Between a rising edge and the next falling edge, it keeps its previous value.
- R7: With two stages chained, 2×WIDTH shifts fill both stages as one 2×WIDTH-bit chain. The first bit shifted in ends up in the top bit of the far stage.
- R8: After the clear is released, the first SYNC_STAGES edges of each clock leave the registers cleared. With the default SYNC_STAGES of 2, two shift edges and two load edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sh_clk | input | 1 | Shift clock; the chain advances on its rising edge |
| ld_clk | input | 1 | Load clock; the holding register captures on its rising edge |
| clr_n | input | 1 | Asynchronous active-low clear of all registers |
| oe_n | input | 1 | Active-low output enable |
| ser_in | input | 1 | Serial data input |
| sw_on | output | WIDTH | Per-bit switch-on controls, 1 = switch conducting |
| ser_out | output | 1 | Cascade output, retimed on the falling shift-clock edge |

## Verification
On every edge, the assertions check the shift step of the chain, the parallel capture into the holding register and the falling-edge copy into the cascade flop. They also check that the chain is empty whenever the clear is held low. Only the bench scenarios can show the following: the word assembled across two chained stages, that the enable hides the held word without destroying it, that a shift burst without a load edge leaves the outputs alone, and that edges are discarded right after a clear is released.

// File: rtl/drv_pkg.sv
package drv_pkg;

    localparam int DRV_WIDTH_DEF = 8;
    localparam int DRV_SYNC_DEF  = 2;

    typedef enum logic {
        OE_ACTIVE  = 1'b0,
        OE_BLOCKED = 1'b1
    } oe_lvl_e;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;

    function automatic logic gate_bit(input oe_lvl_e lvl, input logic held);
        return (lvl == OE_ACTIVE) ? held : 1'b0;
    endfunction

endpackage

// File: rtl/drv_rst_sync.sv
module drv_rst_sync
    import drv_pkg::*;
#(
    parameter int        STAGES = DRV_SYNC_DEF,
    parameter edge_sel_e EDGE   = EDGE_RISE
) (
    input  logic clk,
    input  logic clr_n,
    output logic rel_n
);

    logic [STAGES-1:0] pipe_q;

    initial begin
        if (STAGES < 2) $error("drv_rst_sync: STAGES must be at least 2");
    end

    generate
        if (EDGE == EDGE_FALL) begin : g_fall
            always_ff @(negedge clk or negedge clr_n) begin
                if (!clr_n) pipe_q <= '0;
                else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
            end
        end else begin : g_rise
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) pipe_q <= '0;
                else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
            end
        end
    endgenerate

    assign rel_n = pipe_q[STAGES-1];

endmodule

// File: rtl/drv_shift_chain.sv
module drv_shift_chain
    import drv_pkg::*;
#(
    parameter int WIDTH = DRV_WIDTH_DEF
) (
    input  logic             sh_clk,
    input  logic             rel_n,
    input  logic             rel_fall_n,
    input  logic             ser_in,
    output logic [WIDTH-1:0] chain_q,
    output logic             ser_out
);

    localparam int TOP = WIDTH - 1;

    always_ff @(posedge sh_clk or negedge rel_n) begin
        if (!rel_n) chain_q <= '0;
        else        chain_q <= {chain_q[TOP-1:0], ser_in};
    end

    // Cascade flop: retimed half a period later for downstream hold margin.
    always_ff @(negedge sh_clk or negedge rel_fall_n) begin
        if (!rel_fall_n) ser_out <= 1'b0;
        else             ser_out <= chain_q[TOP];
    end

    // R1: chain moves up one place and takes the serial input.
    a_r1_shift_step: assert property (@(posedge sh_clk) disable iff (!rel_n)
        1'b1 |=> (chain_q == {$past(chain_q[TOP-1:0]), $past(ser_in)}));

    // R6: the cascade output copies the last stage at the falling edge.
    a_r6_fall_copy: assert property (@(negedge sh_clk) disable iff (!rel_fall_n || !rel_n)
        1'b1 |=> (ser_out == $past(chain_q[TOP])));

endmodule

// File: rtl/drv_hold_reg.sv
module drv_hold_reg
    import drv_pkg::*;
#(
    parameter int WIDTH = DRV_WIDTH_DEF
) (
    input  logic             ld_clk,
    input  logic             rel_n,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] hold_q
);

    always_ff @(posedge ld_clk or negedge rel_n) begin
        if (!rel_n) hold_q <= '0;
        else        hold_q <= par_in;
    end

    // R2: a load edge takes the whole chain in parallel.
    a_r2_parallel_load: assert property (@(posedge ld_clk) disable iff (!rel_n)
        1'b1 |=> (hold_q == $past(par_in)));

endmodule

// File: rtl/drv_latched_sipo.sv
module drv_latched_sipo
    import drv_pkg::*;
#(
    parameter int WIDTH       = DRV_WIDTH_DEF,
    parameter int SYNC_STAGES = DRV_SYNC_DEF
) (
    input  logic             sh_clk,
    input  logic             ld_clk,
    input  logic             clr_n,
    input  logic             oe_n,
    input  logic             ser_in,
    output logic [WIDTH-1:0] sw_on,
    output logic             ser_out
);

    logic             rel_sh_n;
    logic             rel_fall_n;
    logic             rel_ld_n;
    logic [WIDTH-1:0] chain_q;
    logic [WIDTH-1:0] hold_q;
    oe_lvl_e          oe_lvl;

    drv_rst_sync #(.STAGES(SYNC_STAGES), .EDGE(EDGE_RISE)) u_sync_sh (
        .clk(sh_clk), .clr_n(clr_n), .rel_n(rel_sh_n)
    );

    drv_rst_sync #(.STAGES(SYNC_STAGES), .EDGE(EDGE_FALL)) u_sync_fall (
        .clk(sh_clk), .clr_n(clr_n), .rel_n(rel_fall_n)
    );

    drv_rst_sync #(.STAGES(SYNC_STAGES), .EDGE(EDGE_RISE)) u_sync_ld (
        .clk(ld_clk), .clr_n(clr_n), .rel_n(rel_ld_n)
    );

    drv_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .sh_clk    (sh_clk),
        .rel_n     (rel_sh_n),
        .rel_fall_n(rel_fall_n),
        .ser_in    (ser_in),
        .chain_q   (chain_q),
        .ser_out   (ser_out)
    );

    drv_hold_reg #(.WIDTH(WIDTH)) u_hold (
        .ld_clk(ld_clk),
        .rel_n (rel_ld_n),
        .par_in(chain_q),
        .hold_q(hold_q)
    );

    assign oe_lvl = oe_lvl_e'(oe_n);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_gate
            assign sw_on[i] = gate_bit(oe_lvl, hold_q[i]);
        end
    endgenerate

    // R3: with the clear held, the chain and the cascade output are empty.
    a_r3_clear_empties: assert property (@(posedge ld_clk) disable iff (clr_n)
        1'b1 |-> (chain_q == '0 && hold_q == '0 && ser_out == 1'b0));

endmodule

// File: tb/drv_latched_sipo_test.sv
module drv_latched_sipo_test;

    localparam int W  = 8;
    localparam int W2 = 2 * W;
    localparam int SYNC = 2;

    typedef enum logic { K_SW, K_SER } kind_e;
    typedef struct {
        kind_e       kind;
        logic [W2-1:0] exp;
        string       req;
    } item_t;

    logic clk = 1'b0;
    logic sh_clk = 1'b0, ld_clk = 1'b0, clr_n = 1'b0, oe_n = 1'b1, ser_in = 1'b0;
    logic [W-1:0] sw_a, sw_b;
    logic ser_a, ser_b;

    int n_tests = 0, n_fail = 0;
    item_t sb_q[$];
    event  chk_ev;
    bit    done = 1'b0;

    logic [W2-1:0] model = '0;
    logic [W2-1:0] hold_m = '0;
    int skip_sh = 0, skip_ld = 0;

    always #4 clk = ~clk;   // 125 MHz reference

    drv_latched_sipo #(.WIDTH(W), .SYNC_STAGES(SYNC)) uut (
        .sh_clk(sh_clk), .ld_clk(ld_clk), .clr_n(clr_n), .oe_n(oe_n),
        .ser_in(ser_in), .sw_on(sw_a), .ser_out(ser_a)
    );

    drv_latched_sipo #(.WIDTH(W), .SYNC_STAGES(SYNC)) stage_b (
        .sh_clk(sh_clk), .ld_clk(ld_clk), .clr_n(clr_n), .oe_n(oe_n),
        .ser_in(ser_a), .sw_on(sw_b), .ser_out(ser_b)
    );

    // Monitor: pops expected items and compares them with the ports.
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [W2-1:0] act;
                it  = sb_q.pop_front();
                act = (it.kind == K_SW) ? {sw_b, sw_a} : {{(W2-1){1'b0}}, ser_a};
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic push(input kind_e k, input logic [W2-1:0] e, input string req);
        item_t it;
        it.kind = k; it.exp = e; it.req = req;
        sb_q.push_back(it);
        -> chk_ev;
        #0;
    endtask

    task automatic expect_sw(input string req);
        push(K_SW, oe_n ? '0 : hold_m, req);
    endtask

    task automatic shift_bit(input logic b, input bit chk_ser);
        logic old_top;
        old_top = model[W-1];
        ser_in = b;
        #4 sh_clk = 1'b1;
        if (skip_sh > 0) skip_sh--;
        else model = {model[W2-2:0], b};
        #1;
        if (chk_ser) push(K_SER, {{(W2-1){1'b0}}, old_top}, "R6 held before fall");
        #3 sh_clk = 1'b0;
        #1;
        if (chk_ser) push(K_SER, {{(W2-1){1'b0}}, model[W-1]}, "R6 updated at fall");
        #3;
    endtask

    task automatic load_pulse();
        #4 ld_clk = 1'b1;
        if (skip_ld > 0) skip_ld--;
        else hold_m = model;
        #4 ld_clk = 1'b0;
        #4;
    endtask

    task automatic shift_word(input logic [W2-1:0] w, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) shift_bit(w[i], 1'b0);
    endtask

    task automatic do_clear();
        #3 clr_n = 1'b0;
        model = '0; hold_m = '0;
        #3;
    endtask

    task automatic do_release();
        #3 clr_n = 1'b1;
        skip_sh = SYNC; skip_ld = SYNC;
        #3;
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #10;
        oe_n = 1'b0;
        expect_sw("R3 reset outputs");
        push(K_SER, '0, "R3 reset serial out");
        do_release();

        // R8: first edges after release are discarded.
        shift_bit(1'b1, 1'b0);
        shift_bit(1'b1, 1'b0);
        load_pulse();
        load_pulse();
        push(K_SW, '0, "R8 edges after release ignored");

        // R1 R7 R5: fill both stages with a 16-bit word.
        shift_word(16'hA5C3, W2);
        push(K_SW, '0, "R2 no load edge yet");
        load_pulse();
        push(K_SW, 16'hA5C3, "R7 two-stage word");
        expect_sw("R5 outputs follow hold");

        // R4: enable off hides the word, shifting meanwhile.
        oe_n = 1'b1; #2;
        push(K_SW, '0, "R4 outputs off");
        shift_word(16'h003C, W);
        oe_n = 1'b0; #2;
        push(K_SW, 16'hA5C3, "R4 hold kept while disabled");
        push(K_SW, 16'hA5C3, "R2 shift without load");
        load_pulse();
        push(K_SW, 16'hC33C, "R1 R2 new capture after 8 shifts");

        // R6: serial output timing on a few shifts.
        shift_bit(1'b0, 1'b1);
        shift_bit(1'b1, 1'b1);
        shift_bit(1'b1, 1'b1);
        shift_bit(1'b0, 1'b1);

        // R1: walking one through the 16-bit chain.
        shift_word('0, W2);
        shift_bit(1'b1, 1'b0);
        for (int k = 0; k < W2; k++) begin
            load_pulse();
            expect_sw("R1 walking one");
            if (k < W2 - 1) shift_bit(1'b0, 1'b0);
        end

        // R3: clear in the middle of a stream.
        shift_word(16'h0015, 5);
        do_clear();
        push(K_SW, '0, "R3 clear mid-stream outputs");
        push(K_SER, '0, "R3 clear mid-stream serial out");
        shift_bit(1'b1, 1'b0);
        load_pulse();
        push(K_SW, '0, "R3 edges ignored while cleared");
        do_release();
        shift_bit(1'b1, 1'b0);
        shift_bit(1'b1, 1'b0);
        shift_word(16'h5A96, W2);
        load_pulse();
        push(K_SW, '0, "R8 first load after release ignored");
        load_pulse();
        push(K_SW, '0, "R8 second load after release ignored");
        load_pulse();
        push(K_SW, 16'h5A96, "R7 word after clear");

        #20;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule